// File: doc/BRIEF.md
# Write-Back Data Cache

This block is a direct-mapped data cache placed between a load/store unit and a line-wide memory port. Each request carries an access size (idle, byte, half word or word), a read/write select, a 32-bit address and 32-bit store data. A hit answers in the cycle the request is presented. A load hit raises a read-valid strobe with the selected bytes placed at the low end of the result. A store hit merges the bytes into the line and raises a write-done strobe.

On a miss the cache raises a miss flag together with a line address. If the line being replaced holds modified data, the cache first offers that whole line for writing back and holds it until memory acknowledges. It then asks for the new line and waits for a full-line fill. A load completes in the fill cycle with data taken from the incoming line. A store completes in the fill cycle by merging its bytes into the incoming line and marking the line modified. Addresses at or above a configurable boundary belong to I/O space. Those requests bypass the cache and go to a word-wide I/O port.

The requester holds a request steady until it sees read-valid or write-done in a cycle, and removes or changes the request in the next cycle.

Top module: `wb_dcache`

## Requirements
- R1: With `req_kind` = 00 the block raises none of `rd_vld`, `wr_done`, `miss` and `io_req`, and a store presented with that code leaves the cached data unchanged.
- R2: A load (`req_rd` = 1) that hits raises `rd_vld` in the same cycle. A byte (`req_kind` 01) returns the byte at address offset [3:0]. A half word (10) returns the byte pair at offset [3:1]. A word (11) returns the word at offset [3:2]. Each result is placed at bit 0 and zero-extended.
- R3: A store (`req_rd` = 0) that hits writes only the addressed byte, half word or word, raises `wr_done` for that one cycle, and raises neither `miss` nor `mem_wr`.
- R4: A miss on a clean or empty line raises `miss` in the next cycle with `mem_wr` = 0 and `miss_line_addr` = address [31:4]. A load completes with `rd_vld` in the cycle `fill_vld` is high, and a later load to that line hits without a fill.
- R5: A miss on a modified line first raises `mem_wr` = 1 with `miss_line_addr` set to the old line address and `wb_line` set to the old line. This holds until `wr_ack`. In the next cycle the block asks for a read of the new line.
- R6: A store that misses is merged into the fill line and raises `wr_done` in the fill cycle. The line is then modified, so its later eviction writes back the merged data.
- R7: Memory is written only when a modified line is evicted. Replacing a line that was only read produces no write-back cycle.
- R8: Reset invalidates every line, so the first access to any cached address afterwards misses.
- R9: Addresses at or above `IO_BASE` (default 0x0003_0000) raise `io_req` from the next cycle with `io_addr`, `io_wr` = !`req_rd`, `io_size` and `io_wdata` taken from the request. The request completes with `io_done`, and a load returns `io_rdata` zero-extended to its size. Such data is never cached, so a repeated access goes to the I/O port again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_kind | input | 2 | Access size: 00 idle, 01 byte, 10 half word, 11 word |
| req_rd | input | 1 | 1 = load, 0 = store |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rd_vld | output | 1 | Load result valid this cycle |
| rd_data | output | 32 | Load result, right-aligned and zero-extended |
| wr_done | output | 1 | Store completed this cycle |
| miss | output | 1 | Line transfer with memory in progress |
| mem_wr | output | 1 | 1 = write-back of the old line, 0 = line read request |
| miss_line_addr | output | 28 | Line address of the transfer |
| wb_line | output | 128 | Old line data for write-back |
| wr_ack | input | 1 | Memory accepted the write-back |
| fill_vld | input | 1 | Fill line present on `fill_line` |
| fill_line | input | 128 | Line data from memory |
| io_req | output | 1 | I/O access in progress |
| io_wr | output | 1 | I/O access is a store |
| io_addr | output | 32 | I/O byte address |
| io_wdata | output | 32 | I/O store data |
| io_size | output | 2 | I/O access size, same code as `req_kind` |
| io_done | input | 1 | I/O access finished |
| io_rdata | input | 32 | I/O load data, right-aligned |

## Verification
The assertions assume that the requester keeps a request unchanged while `miss` or `io_req` is high, and that it withdraws or replaces the request in the cycle after `rd_vld` or `wr_done`. This is what makes the single-cycle write-done pulse and the idle checks meaningful. They also assume that memory raises `wr_ack` only during a write-back and `fill_vld` only during a read request. The stimulus meets these assumptions through one access routine. That routine drives the request at the falling edge, answers memory and I/O only in the phase being shown, and sets `req_kind` to idle right after a response.

// File: rtl/wb_dcache_pkg.sv
package wb_dcache_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'b00,
      ACC_BYTE = 2'b01,
      ACC_HALF = 2'b10,
      ACC_WORD = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVICT = 2'd1,
      ST_FILL  = 2'd2,
      ST_IO    = 2'd3
   } dc_state_e;

   function automatic logic [31:0] size_mask(input logic [1:0] kind);
      logic [31:0] m;
      case (kind)
         ACC_BYTE: m = 32'h0000_00FF;
         ACC_HALF: m = 32'h0000_FFFF;
         ACC_WORD: m = 32'hFFFF_FFFF;
         default:  m = 32'h0000_0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
   parameter int INDEX_W = 3,
   parameter int TAG_W   = 25
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INDEX_W-1:0] idx,
   input  logic               install,
   input  logic [TAG_W-1:0]   new_tag,
   input  logic               new_dirty,
   input  logic               set_dirty,
   input  logic               clr_dirty,
   output logic               line_valid,
   output logic               line_dirty,
   output logic [TAG_W-1:0]   line_tag
);
   localparam int LINES = 1 << INDEX_W;

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (install) begin
         valid_q[idx] <= 1'b1;
         dirty_q[idx] <= new_dirty;
      end else if (set_dirty) begin
         dirty_q[idx] <= 1'b1;
      end else if (clr_dirty) begin
         dirty_q[idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (install) tag_q[idx] <= new_tag;
   end

   assign line_valid = valid_q[idx];
   assign line_dirty = dirty_q[idx];
   assign line_tag   = tag_q[idx];

endmodule

// File: rtl/dc_line_store.sv
module dc_line_store #(
   parameter int INDEX_W = 3,
   parameter int LINE_W  = 128
) (
   input  logic               clk,
   input  logic               we,
   input  logic [INDEX_W-1:0] idx,
   input  logic [LINE_W-1:0]  wline,
   output logic [LINE_W-1:0]  rline
);
   localparam int LINES = 1 << INDEX_W;

   logic [LINE_W-1:0] mem_q [LINES];

   always_ff @(posedge clk) begin
      if (we) mem_q[idx] <= wline;
   end

   assign rline = mem_q[idx];

endmodule

// File: rtl/dc_lane.sv
module dc_lane
   import wb_dcache_pkg::*;
#(
   parameter int OFFSET_W = 4
) (
   input  logic [(8<<OFFSET_W)-1:0] src_line,
   input  logic [OFFSET_W-1:0]      offset,
   input  logic [1:0]               kind,
   input  logic [31:0]              wdata,
   output logic [(8<<OFFSET_W)-1:0] merged,
   output logic [31:0]              load_word
);
   localparam int BYTES = 1 << OFFSET_W;
   localparam int WORDS = BYTES / 4;

   // store merge: one enable and one source byte per line byte
   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      localparam logic [OFFSET_W-1:0] BI = OFFSET_W'(b);
      logic       en;
      logic [7:0] d;
      always_comb begin
         case (kind)
            ACC_BYTE: begin
               en = (offset == BI);
               d  = wdata[7:0];
            end
            ACC_HALF: begin
               en = (offset[OFFSET_W-1:1] == BI[OFFSET_W-1:1]);
               d  = BI[0] ? wdata[15:8] : wdata[7:0];
            end
            ACC_WORD: begin
               en = (offset[OFFSET_W-1:2] == BI[OFFSET_W-1:2]);
               d  = wdata[8*(b%4) +: 8];
            end
            default: begin
               en = 1'b0;
               d  = 8'h00;
            end
         endcase
      end
      assign merged[8*b +: 8] = en ? d : src_line[8*b +: 8];
   end

   // load extraction
   logic [31:0] words [WORDS];
   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign words[w] = src_line[32*w +: 32];
   end

   logic [31:0] word_sel;
   logic [7:0]  byte_sel;
   logic [15:0] half_sel;

   always_comb begin
      word_sel = words[offset[OFFSET_W-1:2]];
      case (offset[1:0])
         2'd0:    byte_sel = word_sel[7:0];
         2'd1:    byte_sel = word_sel[15:8];
         2'd2:    byte_sel = word_sel[23:16];
         default: byte_sel = word_sel[31:24];
      endcase
      half_sel = offset[1] ? word_sel[31:16] : word_sel[15:0];
      case (kind)
         ACC_BYTE: load_word = {24'h0, byte_sel};
         ACC_HALF: load_word = {16'h0, half_sel};
         ACC_WORD: load_word = word_sel;
         default:  load_word = 32'h0;
      endcase
   end

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
   import wb_dcache_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      active,
   input  logic      rd,
   input  logic      is_io,
   input  logic      hit,
   input  logic      victim_dirty,
   input  logic      wr_ack,
   input  logic      fill_vld,
   input  logic      io_done,
   output dc_state_e state,
   output logic      load_hit,
   output logic      store_hit,
   output logic      clr_dirty,
   output logic      install,
   output logic      io_fin
);
   dc_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: begin
            if (active) begin
               if (is_io)       st_d = ST_IO;
               else if (!hit)   st_d = victim_dirty ? ST_EVICT : ST_FILL;
            end
         end
         ST_EVICT: if (wr_ack)   st_d = ST_FILL;
         ST_FILL:  if (fill_vld) st_d = ST_IDLE;
         ST_IO:    if (io_done)  st_d = ST_IDLE;
         default:                st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

   logic idle_cached;
   assign idle_cached = (st_q == ST_IDLE) && active && !is_io && hit;

   assign state     = st_q;
   assign load_hit  = idle_cached && rd;
   assign store_hit = idle_cached && !rd;
   assign clr_dirty = (st_q == ST_EVICT) && wr_ack;
   assign install   = (st_q == ST_FILL) && fill_vld;
   assign io_fin    = (st_q == ST_IO) && io_done;

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
   import wb_dcache_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          OFFSET_W = 4,
   parameter int          INDEX_W  = 3,
   parameter bit          IO_EN    = 1'b1,
   parameter logic [31:0] IO_BASE  = 32'h0003_0000
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [1:0]                 req_kind,
   input  logic                       req_rd,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [31:0]                req_wdata,
   output logic                       rd_vld,
   output logic [31:0]                rd_data,
   output logic                       wr_done,
   output logic                       miss,
   output logic                       mem_wr,
   output logic [ADDR_W-OFFSET_W-1:0] miss_line_addr,
   output logic [(8<<OFFSET_W)-1:0]   wb_line,
   input  logic                       wr_ack,
   input  logic                       fill_vld,
   input  logic [(8<<OFFSET_W)-1:0]   fill_line,
   output logic                       io_req,
   output logic                       io_wr,
   output logic [ADDR_W-1:0]          io_addr,
   output logic [31:0]                io_wdata,
   output logic [1:0]                 io_size,
   input  logic                       io_done,
   input  logic [31:0]                io_rdata
);
   localparam int LINE_W = 8 << OFFSET_W;
   localparam int TAG_W  = ADDR_W - OFFSET_W - INDEX_W;

   // elaboration-time parameter checks
   if (OFFSET_W < 3) begin : g_bad_offset
      $error("wb_dcache: OFFSET_W must be at least 3 (two words per line)");
   end
   if (INDEX_W < 1) begin : g_bad_index
      $error("wb_dcache: INDEX_W must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wb_dcache: address too narrow for offset and index");
   end

   // address fields
   logic [OFFSET_W-1:0] a_off;
   logic [INDEX_W-1:0]  a_idx;
   logic [TAG_W-1:0]    a_tag;
   assign a_off = req_addr[OFFSET_W-1:0];
   assign a_idx = req_addr[OFFSET_W +: INDEX_W];
   assign a_tag = req_addr[ADDR_W-1 -: TAG_W];

   // I/O window decode
   logic is_io;
   if (IO_EN) begin : g_io
      assign is_io = (req_addr >= ADDR_W'(IO_BASE));
   end else begin : g_no_io
      assign is_io = 1'b0;
   end

   logic active;
   assign active = (req_kind != ACC_NONE);

   // control
   dc_state_e state;
   logic load_hit, store_hit, clr_dirty, install, io_fin;
   logic line_valid, line_dirty, hit;
   logic [TAG_W-1:0] line_tag;

   assign hit = line_valid && (line_tag == a_tag);

   dc_ctrl u_ctrl (
      .clk          (clk),
      .rst          (rst),
      .active       (active),
      .rd           (req_rd),
      .is_io        (is_io),
      .hit          (hit),
      .victim_dirty (line_dirty),
      .wr_ack       (wr_ack),
      .fill_vld     (fill_vld),
      .io_done      (io_done),
      .state        (state),
      .load_hit     (load_hit),
      .store_hit    (store_hit),
      .clr_dirty    (clr_dirty),
      .install      (install),
      .io_fin       (io_fin)
   );

   // tag, valid and dirty bits
   dc_tag_store #(
      .INDEX_W (INDEX_W),
      .TAG_W   (TAG_W)
   ) u_tags (
      .clk        (clk),
      .rst        (rst),
      .idx        (a_idx),
      .install    (install),
      .new_tag    (a_tag),
      .new_dirty  (!req_rd),
      .set_dirty  (store_hit),
      .clr_dirty  (clr_dirty),
      .line_valid (line_valid),
      .line_dirty (line_dirty),
      .line_tag   (line_tag)
   );

   // line data
   logic [LINE_W-1:0] stored_line, src_line, merged_line, write_line;
   logic [31:0]       load_word;
   logic              data_we;

   assign src_line   = (state == ST_FILL) ? fill_line : stored_line;
   assign data_we    = store_hit || install;
   assign write_line = (install && req_rd) ? fill_line : merged_line;

   dc_line_store #(
      .INDEX_W (INDEX_W),
      .LINE_W  (LINE_W)
   ) u_lines (
      .clk   (clk),
      .we    (data_we),
      .idx   (a_idx),
      .wline (write_line),
      .rline (stored_line)
   );

   dc_lane #(
      .OFFSET_W (OFFSET_W)
   ) u_lane (
      .src_line  (src_line),
      .offset    (a_off),
      .kind      (req_kind),
      .wdata     (req_wdata),
      .merged    (merged_line),
      .load_word (load_word)
   );

   // requester side
   assign rd_vld  = load_hit  || ((install || io_fin) && req_rd);
   assign wr_done = store_hit || ((install || io_fin) && !req_rd);
   assign rd_data = (state == ST_IO) ? (io_rdata & size_mask(req_kind)) : load_word;

   // memory side
   assign miss           = (state == ST_EVICT) || (state == ST_FILL);
   assign mem_wr         = (state == ST_EVICT);
   assign miss_line_addr = (state == ST_EVICT) ? {line_tag, a_idx}
                                               : req_addr[ADDR_W-1:OFFSET_W];
   assign wb_line        = stored_line;

   // I/O side
   assign io_req   = (state == ST_IO);
   assign io_wr    = !req_rd;
   assign io_addr  = req_addr;
   assign io_wdata = req_wdata;
   assign io_size  = req_kind;

endmodule

// File: rtl/wb_dcache_chk.sv
module wb_dcache_chk #(
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 4
) (
   input logic                       clk,
   input logic                       rst,
   input logic [1:0]                 req_kind,
   input logic                       rd_vld,
   input logic                       wr_done,
   input logic                       miss,
   input logic                       mem_wr,
   input logic [ADDR_W-OFFSET_W-1:0] miss_line_addr,
   input logic                       wr_ack,
   input logic                       fill_vld,
   input logic                       io_req,
   input logic                       io_done
);
   AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (rst)
      (req_kind == 2'b00 && !miss && !io_req) |-> (!rd_vld && !wr_done)); // R1

   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
      (req_kind == 2'b00 && !miss && !io_req) |=> (!miss && !io_req)); // R1

   AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(rd_vld && wr_done)); // R2

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
      wr_done |=> !wr_done); // R3

   AST_FILL_ENDS: assert property (@(posedge clk) disable iff (rst)
      (miss && !mem_wr && fill_vld) |=> !miss); // R4

   AST_EVICT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && !wr_ack) |=> (mem_wr && $stable(miss_line_addr))); // R5

   AST_EVICT_THEN_READ: assert property (@(posedge clk) disable iff (rst)
      (mem_wr && wr_ack) |=> (miss && !mem_wr)); // R5

   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!miss && !io_req)); // R8

   AST_IO_NO_MISS: assert property (@(posedge clk) disable iff (rst)
      io_req |-> !miss); // R9

   AST_IO_ENDS: assert property (@(posedge clk) disable iff (rst)
      (io_req && io_done) |=> !io_req); // R9

endmodule

bind wb_dcache wb_dcache_chk #(
   .ADDR_W   (ADDR_W),
   .OFFSET_W (OFFSET_W)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .req_kind       (req_kind),
   .rd_vld         (rd_vld),
   .wr_done        (wr_done),
   .miss           (miss),
   .mem_wr         (mem_wr),
   .miss_line_addr (miss_line_addr),
   .wr_ack         (wr_ack),
   .fill_vld       (fill_vld),
   .io_req         (io_req),
   .io_done        (io_done)
);

// File: tb/tb_wb_dcache.sv
`timescale 1ns/1ps
module tb_wb_dcache;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [1:0]   req_kind = 2'b00;
   logic         req_rd = 1'b1;
   logic [31:0]  req_addr = '0;
   logic [31:0]  req_wdata = '0;
   logic         rd_vld, wr_done, miss, mem_wr;
   logic [31:0]  rd_data;
   logic [27:0]  miss_line_addr;
   logic [127:0] wb_line;
   logic         wr_ack = 1'b0;
   logic         fill_vld = 1'b0;
   logic [127:0] fill_line = '0;
   logic         io_req, io_wr;
   logic [31:0]  io_addr, io_wdata;
   logic [1:0]   io_size;
   logic         io_done = 1'b0;
   logic [31:0]  io_rdata = '0;

   always #2.5 clk = ~clk;

   wb_dcache dut (
      .clk(clk), .rst(rst), .req_kind(req_kind), .req_rd(req_rd),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_vld(rd_vld),
      .rd_data(rd_data), .wr_done(wr_done), .miss(miss), .mem_wr(mem_wr),
      .miss_line_addr(miss_line_addr), .wb_line(wb_line), .wr_ack(wr_ack),
      .fill_vld(fill_vld), .fill_line(fill_line), .io_req(io_req),
      .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_size(io_size), .io_done(io_done), .io_rdata(io_rdata)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // results of the last access
   bit           got_rd, got_wr;
   logic [31:0]  got_data;
   int           n_wb, n_fill, n_io, rsp_cycle;
   logic [27:0]  wb_addr, fill_addr;
   logic [127:0] wb_data;
   logic [31:0]  io_a, io_wd;
   logic         io_w;
   int           wb_delay = 0;
   logic [31:0]  io_resp = 32'h0;

   function automatic logic [127:0] pat_line(input logic [27:0] la);
      logic [127:0] l;
      for (int k = 0; k < 4; k++) l[32*k +: 32] = {la, 4'(4*k)} ^ 32'h5A5A_0000;
      return l;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_access(input logic [1:0] k, input logic rd,
                            input logic [31:0] a, input logic [31:0] wd);
      bit fin = 0;
      int held = 0;
      got_rd = 0; got_wr = 0; got_data = 'x;
      n_wb = 0; n_fill = 0; n_io = 0; rsp_cycle = -1;
      @(negedge clk);
      req_kind = k; req_rd = rd; req_addr = a; req_wdata = wd;
      for (int c = 0; c < 60 && !fin; c++) begin
         #1;
         if (miss && mem_wr) begin
            n_wb++;
            wb_addr = miss_line_addr;
            wb_data = wb_line;
            if (held < wb_delay) held++;
            else wr_ack = 1'b1;
         end else if (miss) begin
            n_fill++;
            fill_addr = miss_line_addr;
            fill_line = pat_line(miss_line_addr);
            fill_vld  = 1'b1;
         end
         if (io_req) begin
            n_io++;
            io_a = io_addr; io_w = io_wr; io_wd = io_wdata;
            io_rdata = io_resp;
            io_done = 1'b1;
         end
         #1;
         if (rd_vld)  begin got_rd = 1; got_data = rd_data; fin = 1; end
         if (wr_done) begin got_wr = 1; fin = 1; end
         if (fin) rsp_cycle = c;
         @(negedge clk);
         wr_ack = 1'b0; fill_vld = 1'b0; io_done = 1'b0;
         if (fin) req_kind = 2'b00;
      end
   endtask

   task automatic pulse_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset_state();
      #1;
      chk("R8 reset miss", {31'b0, miss}, 32'd0);
      chk("R8 reset rd_vld", {31'b0, rd_vld}, 32'd0);
      chk("R8 reset wr_done", {31'b0, wr_done}, 32'd0);
      chk("R8 reset io_req", {31'b0, io_req}, 32'd0);
   endtask

   task automatic t_clean_miss();
      do_access(2'b11, 1'b1, 32'h100, 32'h0);
      chk("R8 first access misses", n_fill, 1);
      chk("R4 fill line addr", {4'b0, fill_addr}, 32'h10);
      chk("R4 no writeback", n_wb, 0);
      chk("R4 load data from fill", got_data, 32'h5A5A_0100);
      chk("R4 rd_vld in fill cycle", {31'b0, got_rd}, 32'd1);
      do_access(2'b11, 1'b1, 32'h104, 32'h0);
      chk("R4 later load hits", n_fill, 0);
      chk("R2 word hit data", got_data, 32'h5A5A_0104);
      chk("R2 hit in first cycle", rsp_cycle, 0);
   endtask

   task automatic t_idle();
      @(negedge clk);
      req_kind = 2'b00; req_rd = 1'b0; req_addr = 32'h100; req_wdata = 32'hFFFF_FFFF;
      for (int c = 0; c < 3; c++) begin
         #1;
         chk("R1 idle outputs", {28'b0, rd_vld, wr_done, miss, io_req}, 32'd0);
         @(negedge clk);
      end
      req_rd = 1'b1;
      do_access(2'b11, 1'b1, 32'h100, 32'h0);
      chk("R1 idle store ignored", got_data, 32'h5A5A_0100);
   endtask

   task automatic t_sub_loads();
      do_access(2'b01, 1'b1, 32'h105, 32'h0);
      chk("R2 byte load", got_data, 32'h0000_0001);
      do_access(2'b01, 1'b1, 32'h107, 32'h0);
      chk("R2 top byte zero-extended", got_data, 32'h0000_005A);
      do_access(2'b10, 1'b1, 32'h106, 32'h0);
      chk("R2 half load", got_data, 32'h0000_5A5A);
   endtask

   task automatic t_store_hit();
      do_access(2'b01, 1'b0, 32'h101, 32'hFFFF_FFEE);
      chk("R3 byte store done", {31'b0, got_wr}, 32'd1);
      chk("R3 no miss on hit", n_wb + n_fill, 0);
      do_access(2'b10, 1'b0, 32'h10A, 32'h1234_BEEF);
      chk("R3 half store done", {31'b0, got_wr}, 32'd1);
      do_access(2'b11, 1'b1, 32'h100, 32'h0);
      chk("R3 byte merged", got_data, 32'h5A5A_EE00);
      do_access(2'b11, 1'b1, 32'h108, 32'h0);
      chk("R3 half merged", got_data, 32'hBEEF_0108);
   endtask

   task automatic t_dirty_evict();
      wb_delay = 3;
      do_access(2'b11, 1'b1, 32'h180, 32'h0);
      wb_delay = 0;
      chk("R5 writeback held until ack", n_wb, 4);
      chk("R5 writeback addr", {4'b0, wb_addr}, 32'h10);
      chk("R5 wb word0", wb_data[31:0],   32'h5A5A_EE00);
      chk("R5 wb word2", wb_data[95:64],  32'hBEEF_0108);
      chk("R5 wb word3", wb_data[127:96], 32'h5A5A_010C);
      chk("R5 refill after writeback", {4'b0, fill_addr}, 32'h18);
      chk("R5 load data", got_data, 32'h5A5A_0180);
      do_access(2'b11, 1'b1, 32'h200, 32'h0);
      chk("R7 clean line not written back", n_wb, 0);
      chk("R7 clean evict load", got_data, 32'h5A5A_0200);
   endtask

   task automatic t_store_miss();
      do_access(2'b11, 1'b0, 32'h314, 32'hCAFE_F00D);
      chk("R6 store miss fills", n_fill, 1);
      chk("R6 wr_done in fill", {31'b0, got_wr}, 32'd1);
      do_access(2'b11, 1'b1, 32'h314, 32'h0);
      chk("R6 merged line hit", n_fill, 0);
      chk("R6 merged data", got_data, 32'hCAFE_F00D);
      do_access(2'b11, 1'b1, 32'h394, 32'h0);
      chk("R6 dirty after fill store", n_wb, 1);
      chk("R6 wb addr", {4'b0, wb_addr}, 32'h31);
      chk("R6 wb merged word", wb_data[63:32], 32'hCAFE_F00D);
      chk("R6 wb other word", wb_data[31:0], 32'h5A5A_0310);
      chk("R6 new load", got_data, 32'h5A5A_0394);
   endtask

   task automatic t_reset_inval();
      do_access(2'b11, 1'b1, 32'h394, 32'h0);
      chk("R8 cached before reset", n_fill, 0);
      pulse_reset();
      do_access(2'b11, 1'b1, 32'h394, 32'h0);
      chk("R8 invalid after reset", n_fill, 1);
      chk("R8 no writeback after reset", n_wb, 0);
   endtask

   task automatic t_io();
      io_resp = 32'h1234_56AB;
      do_access(2'b11, 1'b1, 32'h0003_0004, 32'h0);
      chk("R9 io forwarded", n_io, 1);
      chk("R9 io addr", io_a, 32'h0003_0004);
      chk("R9 io load data", got_data, 32'h1234_56AB);
      chk("R9 io no miss", n_fill + n_wb, 0);
      do_access(2'b01, 1'b1, 32'h0003_0008, 32'h0);
      chk("R9 io byte zero-extended", got_data, 32'h0000_00AB);
      do_access(2'b11, 1'b0, 32'h0003_000C, 32'hDEAD_BEEF);
      chk("R9 io store dir", {31'b0, io_w}, 32'd1);
      chk("R9 io store data", io_wd, 32'hDEAD_BEEF);
      chk("R9 io store done", {31'b0, got_wr}, 32'd1);
      do_access(2'b11, 1'b1, 32'h0003_0004, 32'h0);
      chk("R9 io not cached", n_io, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_clean_miss();
      t_idle();
      t_sub_loads();
      t_store_hit();
      t_dirty_evict();
      t_store_miss();
      t_reset_inval();
      t_io();
      repeat (2) @(negedge clk);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule